// File: doc/BRIEF.md
# External Interrupt Pin Conditioner

This block takes four asynchronous external interrupt pins, removes short glitches from each with a digital noise filter, detects the configured edge on the cleaned signal and sets a per-source interrupt latch. Every pin is first brought into the clock domain through a two-stage synchroniser. The synchronised level is then sampled on a periodic strobe. The cleaned level changes only after three strobe samples in a row disagree with it. The strobe period depends on the pin. For one pin it also depends on a range bit in the control register.

An 8-bit control register holds the noise range of source 1, the enable of source 0 and the edge polarities of sources 1 to 3. Source 0 always reacts to a falling edge, and only while its enable bit is set. A latch stays set until the CPU side pulses its clear line. A request leaves the block only when the master enable and the latch's own source enable are both 1.

Top module: `ext_irq_cond`

## Requirements
- R1: After synchronous reset, `ctl_q` reads 0x00 and every bit of `latch_q` and `irq_req` is 0.
- R2: A write stores data bits 7 (source 1 noise range), 6 (source 0 enable) and 4, 3, 2 (edge select of sources 3, 2, 1). Bits 5, 1 and 0 always read back as 0.
- R3: Source 0 filters with a 2-cycle strobe. A falling pulse of 1 cycle never sets its latch, and a level held for 7 cycles or more is always accepted.
- R4: Source 1 filters with a 16-cycle strobe when bit 7 is 1: pulses of 14 cycles are rejected and pulses of 49 or more are accepted. With bit 7 at 0 the strobe is 64 cycles: pulses of 62 are rejected and pulses of 193 or more are accepted.
- R5: Sources 2 and 3 filter with an 8-cycle strobe: pulses of 6 cycles are rejected and pulses of 25 or more are accepted.
- R6: For sources 1 to 3, an edge-select bit of 0 latches a rising filtered edge and 1 latches a falling one. Source 0 ignores rising edges.
- R7: While bit 6 is 0, no activity on pin 0 sets latch 0.
- R8: A set latch holds until its `latch_clr` bit is 1. An accepted edge in the same cycle as a clear leaves the latch set.
- R9: `irq_req[i]` is 1 exactly when `latch_q[i]`, `src_en[i]` and `master_en` are all 1.
- R10: The filtered level changes only on a strobe cycle, and only to the value that the three most recent strobe samples agreed on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-frequency clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_raw | input | 4 | Asynchronous external interrupt pins, bit i is source i |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_q | output | 8 | Control register contents |
| latch_clr | input | 4 | Per-source latch clear pulse |
| master_en | input | 1 | Master interrupt enable |
| src_en | input | 4 | Per-source interrupt enable |
| latch_q | output | 4 | Interrupt latches |
| irq_req | output | 4 | Gated interrupt requests |

## Verification
The assertions assume that reset is held for at least one clock edge, so that synchroniser, strobe and agreement state start from known values. They also assume that `latch_clr`, `ctl_we` and the enables change only between clock edges. The bench drives every input one time unit after a rising edge, so no input moves at a sampling edge. Pins are held at each level long enough to cover the longest filter window before the next stimulus starts. Glitch widths are chosen below the guaranteed-reject bound, and accept widths at or above the stated accept bound.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

    localparam int NPIN       = 4;
    localparam int AGREE_N    = 3;
    localparam int PER_SRC0   = 2;
    localparam int PER_FAST   = 16;
    localparam int PER_SLOW   = 64;
    localparam int PER_SRC23  = 8;

    localparam logic [7:0] CTL_MASK = 8'hDC;

    typedef struct packed {
        logic       nrange;   // bit 7: source 1 noise range, 1 = short
        logic       en0;      // bit 6: source 0 acts as interrupt input
        logic       rsv5;
        logic [2:0] fall_sel; // bits 4..2: sources 3..1, 1 = falling edge
        logic [1:0] rsv;
    } ctl_t;

    // Last strobe phase (period minus one) for a pin.
    function automatic int last_phase(input int idx, input logic nrange,
                                      input int p0, input int pf,
                                      input int ps, input int p23);
        int p;
        if (idx == 0)      p = p0;
        else if (idx == 1) p = nrange ? pf : ps;
        else               p = p23;
        return p - 1;
    endfunction

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[s] <= '0;
            else     stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/eirq_filter.sv
module eirq_filter #(
    parameter int CNT_W   = 6,
    parameter int AGREE_N = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp,
    input  logic [CNT_W-1:0] last_ph,
    output logic             level,
    output logic             rise,
    output logic             fall
);
    localparam int AW = $clog2(AGREE_N + 1);
    localparam logic [AW-1:0] AGREE_LAST = AW'(AGREE_N - 1);

    logic [CNT_W-1:0] phase;
    logic [AW-1:0]    agree;
    logic             stb;

    assign stb = (phase >= last_ph);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            agree <= '0;
            level <= 1'b0;
            rise  <= 1'b0;
            fall  <= 1'b0;
        end else begin
            phase <= stb ? '0 : phase + 1'b1;
            rise  <= 1'b0;
            fall  <= 1'b0;
            if (stb) begin
                if (smp == level) begin
                    agree <= '0;
                end else if (agree == AGREE_LAST) begin
                    agree <= '0;
                    level <= smp;
                    rise  <= smp;
                    fall  <= ~smp;
                end else begin
                    agree <= agree + 1'b1;
                end
            end
        end
    end

    // R10: level moves only on a strobe and toward the sampled value
    p_flip_on_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(level) |-> $past(stb));
    p_flip_to_sample_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(level) |-> (level == $past(smp)));
    p_agree_bound_r10: assert property (@(posedge clk) disable iff (rst)
        agree < AW'(AGREE_N));
endmodule

// File: rtl/eirq_latch.sv
module eirq_latch (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

    // R8: hold until cleared; set beats clear
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (q && !clr) |=> q);
    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        set |=> q);
endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
    import eirq_pkg::*;
#(
    parameter int P_SRC0  = PER_SRC0,
    parameter int P_FAST  = PER_FAST,
    parameter int P_SLOW  = PER_SLOW,
    parameter int P_SRC23 = PER_SRC23,
    parameter int N_AGREE = AGREE_N,
    parameter int SYNC_N  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] pin_raw,
    input  logic       ctl_we,
    input  logic [7:0] ctl_wdata,
    output logic [7:0] ctl_q,
    input  logic [3:0] latch_clr,
    input  logic       master_en,
    input  logic [3:0] src_en,
    output logic [3:0] latch_q,
    output logic [3:0] irq_req
);
    localparam int CNT_W = $clog2(P_SLOW);

    ctl_t       ctl;
    logic [3:0] pin_s;
    logic [3:0] lvl, rise, fall, set;

    always_ff @(posedge clk) begin
        if (rst)         ctl <= '0;
        else if (ctl_we) ctl <= ctl_t'(ctl_wdata & CTL_MASK);
    end
    assign ctl_q = ctl;

    eirq_sync #(.W(NPIN), .STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst(rst), .d(pin_raw), .q(pin_s)
    );

    for (genvar i = 0; i < NPIN; i++) begin : g_src
        logic [CNT_W-1:0] last_ph;
        assign last_ph = CNT_W'(last_phase(i, ctl.nrange,
                                           P_SRC0, P_FAST, P_SLOW, P_SRC23));

        eirq_filter #(.CNT_W(CNT_W), .AGREE_N(N_AGREE)) u_filt (
            .clk(clk), .rst(rst), .smp(pin_s[i]), .last_ph(last_ph),
            .level(lvl[i]), .rise(rise[i]), .fall(fall[i])
        );

        if (i == 0) begin : g_fixed
            assign set[i] = fall[i] & ctl.en0;
        end else begin : g_sel
            assign set[i] = ctl.fall_sel[i-1] ? fall[i] : rise[i];
        end

        eirq_latch u_latch (
            .clk(clk), .rst(rst), .set(set[i]), .clr(latch_clr[i]),
            .q(latch_q[i])
        );
    end

    assign irq_req = latch_q & src_en & {NPIN{master_en}};

    // R7: with source 0 disabled its latch cannot become set
    p_src0_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (!ctl.en0 && !latch_q[0]) |=> !latch_q[0]);
    // R6: source 0 never latches on a rising filtered edge
    p_src0_no_rise_r6: assert property (@(posedge clk) disable iff (rst)
        (rise[0] && !latch_q[0]) |=> !latch_q[0]);
endmodule

// File: tb/ext_irq_cond_test.sv
`timescale 1ns/1ps
module ext_irq_cond_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] pin_raw = 4'h0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic [7:0] ctl_q;
    logic [3:0] latch_clr = 4'h0;
    logic       master_en = 1'b0;
    logic [3:0] src_en = 4'h0;
    logic [3:0] latch_q, irq_req;

    int n_tests = 0, n_fail = 0;
    bit done = 0;
    int seen_hi2 = 0;

    always #2 clk = ~clk;   // 250 MHz

    ext_irq_cond uut (
        .clk(clk), .rst(rst), .pin_raw(pin_raw), .ctl_we(ctl_we),
        .ctl_wdata(ctl_wdata), .ctl_q(ctl_q), .latch_clr(latch_clr),
        .master_en(master_en), .src_en(src_en), .latch_q(latch_q),
        .irq_req(irq_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_cfg;
    logic [3:0] m_s1, m_s2, m_lvl, m_rise, m_fall, m_lat;
    int         m_ph [4];
    int         m_run [4];   // consecutive strobe samples disagreeing with level

    function automatic int strobe_period(input int i, input logic [7:0] cfg);
        if (i == 0) return 2;
        if (i == 1) return cfg[7] ? 16 : 64;
        return 8;
    endfunction

    always @(posedge clk) begin
        logic [3:0] nl;
        if (rst) begin
            m_cfg = 8'h00; m_s1 = 0; m_s2 = 0; m_lvl = 0;
            m_rise = 0; m_fall = 0; m_lat = 0;
            for (int i = 0; i < 4; i++) begin m_ph[i] = 0; m_run[i] = 0; end
        end else begin
            for (int i = 0; i < 4; i++) begin
                logic hit;
                if (i == 0) hit = m_fall[0] && m_cfg[6];
                else        hit = m_cfg[i+1] ? m_fall[i] : m_rise[i];
                nl[i] = hit || (m_lat[i] && !latch_clr[i]);
            end
            for (int i = 0; i < 4; i++) begin
                bit stb;
                stb = (m_ph[i] >= strobe_period(i, m_cfg) - 1);
                m_ph[i] = stb ? 0 : m_ph[i] + 1;
                m_rise[i] = 0; m_fall[i] = 0;
                if (stb) begin
                    if (m_s2[i] == m_lvl[i]) m_run[i] = 0;
                    else begin
                        m_run[i]++;
                        if (m_run[i] == 3) begin
                            m_run[i] = 0;
                            m_lvl[i] = m_s2[i];
                            m_rise[i] = m_s2[i];
                            m_fall[i] = !m_s2[i];
                        end
                    end
                end
            end
            m_s2 = m_s1;
            m_s1 = pin_raw;
            m_lat = nl;
            if (ctl_we) m_cfg = ctl_wdata & 8'hDC;
        end
    end

    // Compare on every falling edge, away from the active edge.
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R8 model latch_q", latch_q, m_lat);
            chk("R9 model irq_req", irq_req, m_lat & src_en & {4{master_en}});
            chk("R2 model ctl_q", ctl_q, m_cfg);
            if (latch_q[2] && latch_clr[2]) seen_hi2++;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] v);
        ctl_we = 1'b1; ctl_wdata = v; tick(1);
        ctl_we = 1'b0; tick(2);
    endtask

    task automatic hold(input int i, input logic v, input int n);
        pin_raw[i] = v; tick(n);
    endtask

    task automatic clear(input int i);
        latch_clr[i] = 1'b1; tick(1);
        latch_clr[i] = 1'b0; tick(2);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        tick(4);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        chk("R1 ctl_q after reset", ctl_q, 8'h00);
        chk("R1 latch_q after reset", latch_q, 4'h0);
        chk("R1 irq_req after reset", irq_req, 4'h0);

        // R2 reserved bits read 0
        wr(8'hFF);
        chk("R2 ctl_q masked", ctl_q, 8'hDC);
        wr(8'h40);   // source 0 enabled, source 1 long range, all rising
        chk("R2 ctl_q write", ctl_q, 8'h40);

        // Source 0: rising ignored, glitch rejected, long low accepted
        hold(0, 1'b1, 20);
        chk("R6 src0 rising ignored", latch_q[0], 1'b0);
        hold(0, 1'b0, 1); hold(0, 1'b1, 20);
        chk("R3 src0 1-cycle glitch rejected", latch_q[0], 1'b0);
        hold(0, 1'b0, 7); hold(0, 1'b0, 12);
        chk("R3 src0 7-cycle low accepted", latch_q[0], 1'b1);
        tick(50);
        chk("R8 latch holds without clear", latch_q[0], 1'b1);
        clear(0);
        chk("R8 latch cleared", latch_q[0], 1'b0);
        hold(0, 1'b1, 20);

        // R7: source 0 disabled
        wr(8'h00);
        hold(0, 1'b0, 20);
        chk("R7 src0 disabled no latch", latch_q[0], 1'b0);
        hold(0, 1'b1, 20);
        wr(8'h40);

        // Source 2 rising, 8-cycle strobe
        hold(2, 1'b1, 6); hold(2, 1'b0, 40);
        chk("R5 src2 6-cycle pulse rejected", latch_q[2], 1'b0);
        hold(2, 1'b1, 25); hold(2, 1'b0, 40);
        chk("R5 src2 25-cycle pulse accepted", latch_q[2], 1'b1);
        clear(2);

        // Source 3 falling
        wr(8'h50);
        hold(3, 1'b1, 40);
        chk("R6 src3 falling-select ignores rise", latch_q[3], 1'b0);
        hold(3, 1'b0, 6); hold(3, 1'b1, 40);
        chk("R5 src3 6-cycle low rejected", latch_q[3], 1'b0);
        hold(3, 1'b0, 25); hold(3, 1'b0, 40);
        chk("R6 src3 falling edge latched", latch_q[3], 1'b1);
        clear(3);

        // Source 1, long range (64-cycle strobe)
        hold(1, 1'b1, 62); hold(1, 1'b0, 260);
        chk("R4 src1 long range 62 rejected", latch_q[1], 1'b0);
        hold(1, 1'b1, 193); hold(1, 1'b1, 60);
        chk("R4 src1 long range 193 accepted", latch_q[1], 1'b1);
        clear(1);
        hold(1, 1'b0, 260);
        chk("R6 src1 rising-select ignores fall", latch_q[1], 1'b0);

        // Source 1, short range (16-cycle strobe)
        wr(8'hD0);
        tick(70);
        hold(1, 1'b1, 14); hold(1, 1'b0, 80);
        chk("R4 src1 short range 14 rejected", latch_q[1], 1'b0);
        hold(1, 1'b1, 49); hold(1, 1'b1, 40);
        chk("R4 src1 short range 49 accepted", latch_q[1], 1'b1);
        clear(1);

        // R9 gating
        hold(2, 1'b1, 40);
        chk("R9 latch2 set for gating", latch_q[2], 1'b1);
        master_en = 1'b0; src_en = 4'hF; tick(1);
        chk("R9 master off", irq_req, 4'h0);
        master_en = 1'b1; src_en = 4'h4; tick(1);
        chk("R9 source 2 enabled", irq_req, 4'h4);
        src_en = 4'hB; tick(1);
        chk("R9 source 2 disabled", irq_req, 4'h0);

        // R8 set beats clear: clear held while a new edge arrives
        clear(2);
        hold(2, 1'b0, 40);
        seen_hi2 = 0;
        latch_clr[2] = 1'b1;
        hold(2, 1'b1, 40);
        chk("R8 set wins over simultaneous clear", (seen_hi2 > 0), 1'b1);
        latch_clr[2] = 1'b0; tick(2);
        chk("R8 cleared after clear held", latch_q[2], 1'b0);

        tick(5);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule